// File: doc/BRIEF.md
# Start-Bit Framed Serial Transmitter

This block sends a parallel data word over a single serial wire, over and over, with no request from outside. The line rests low. Every frame opens with one high marker bit, and the payload bits follow it, least significant bit first. The line is then held low for a set number of bit periods before the next frame begins. No stop bit is sent. A receiver finds each frame from the rising edge that follows the low gap, and it then counts a fixed number of bit periods.

An internal clock-enable divider sets the bit period from the system clock. A position counter, advanced by that enable, reloads the shift register once the gap has run out. The parallel word is read only on the clock edge that loads the register, and a one-cycle strobe marks that edge. All logic runs on one clock. The reset input is active low, takes effect at once, and is released through a two-stage synchronizer.

Top module: `sframe_tx`

## Requirements
- R1: While `rst_n` is low, `ser_out` and `frame_start` are both 0.
- R2: After `rst_n` is released, the first frame load takes place on clock edge number CLKS_PER_BIT+2. Two of those edges are the reset synchronizer and CLKS_PER_BIT are the first bit period. `frame_start` is 1 in the cycle that follows that edge.
- R3: From each load edge, `ser_out` is 1 for exactly CLKS_PER_BIT clock cycles. This is the start marker.
- R4: After the marker, `ser_out` carries bit 0 through bit DATA_W-1 of the loaded word, in that order. Each bit lasts CLKS_PER_BIT cycles.
- R5: After the last data bit, `ser_out` is 0 for GAP_BITS bit periods. GAP_BITS is at least 2.
- R6: Loads repeat without any outside command, one every (1+DATA_W+GAP_BITS)*CLKS_PER_BIT cycles. `frame_start` is high for exactly one cycle per load and is low at all other times.
- R7: `data_in` is sampled only on the load edge. A change to `data_in` at any other time does not change the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; takes effect at once, released synchronously |
| data_in | input | DATA_W | Parallel word, read on each frame load |
| ser_out | output | 1 | Serial line; idles low |
| frame_start | output | 1 | One-cycle strobe in the first cycle of each frame |

## Verification
The hardest case to reach from the ports is a change to `data_in` while a frame is still shifting out. A correct design gives no sign of such a change, so the bench has to bring it about on purpose. During every data bit period the stimulus writes random words to `data_in`. It then sets the next frame's word only during the low gap, and it checks each serial cycle against the word that was present on the load edge. The directed words all-ones, all-zeros, single end bits and alternating bits show a bit-order fault or a shift off by one.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

  // Total bit periods in one frame: marker + payload + gap.
  function automatic int frame_len(input int data_w, input int gap_bits);
    return 1 + data_w + gap_bits;
  endfunction

  // Width needed to hold values 0..n-1 (at least 1 bit).
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sftx_rst_sync.sv
module sftx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/sftx_bit_timer.sv
module sftx_bit_timer
  import sftx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic bit_tick
);

  localparam int CW = idx_w(CLKS_PER_BIT);

  generate
    if (CLKS_PER_BIT == 1) begin : g_every_clk
      assign bit_tick = 1'b1;
    end else begin : g_divider
      localparam logic [CW-1:0] TOP = CW'(CLKS_PER_BIT - 1);
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;
      logic          at_top;

      always_comb begin
        at_top = (cnt_q == TOP);
        cnt_d  = at_top ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign bit_tick = at_top;

      // R6: the divider never leaves its range, so the bit period stays fixed
      p_div_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);
      // R6: a tick is always followed by a restart of the count
      p_div_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> (cnt_q == '0));
    end
  endgenerate

endmodule

// File: rtl/sftx_frame_seq.sv
module sftx_frame_seq
  import sftx_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int GAP_BITS = 3
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        bit_tick,
  output logic                                        load_now,
  output logic [idx_w(frame_len(DATA_W, GAP_BITS))-1:0] pos_q
);

  localparam int FRAME_BITS = frame_len(DATA_W, GAP_BITS);
  localparam int PW         = idx_w(FRAME_BITS);
  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

  logic [PW-1:0] pos_d;
  logic          at_last;

  always_comb begin
    at_last  = (pos_q == LAST);
    load_now = bit_tick & at_last;
    pos_d    = pos_q;
    if (bit_tick) pos_d = at_last ? '0 : pos_q + 1'b1;
  end

  // Reset parks the position at the last gap slot so the first tick loads.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= LAST;
    else        pos_q <= pos_d;
  end

  // R6: the position only moves on a bit tick
  p_pos_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(pos_q));
  // R3: every load opens the frame at position zero (the marker slot)
  p_load_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (pos_q == '0));
  // R6: the position stays within one frame
  p_pos_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST);

endmodule

// File: rtl/sftx_shifter.sv
module sftx_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              load_now,
  input  logic [DATA_W-1:0] word_in,
  output logic              line_bit,
  output logic              load_strobe
);

  localparam int SW = DATA_W + 1;

  logic [SW-1:0] sh_q;
  logic [SW-1:0] sh_d;
  logic          strobe_q;

  always_comb begin
    sh_d = sh_q;
    if (load_now)      sh_d = {word_in, 1'b1};
    else if (bit_tick) sh_d = {1'b0, sh_q[SW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      strobe_q <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      strobe_q <= load_now;
    end
  end

  assign line_bit    = sh_q[0];
  assign load_strobe = strobe_q;

  // R7: with no tick and no load the register contents do not move
  p_hold_between_ticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !load_now) |=> $stable(sh_q));
  // R3: the first cycle of a frame shows the marker
  p_marker_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |-> line_bit);

endmodule

// File: rtl/sframe_tx.sv
module sframe_tx
  import sftx_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int CLKS_PER_BIT = 4,
  parameter int GAP_BITS     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_in,
  output logic              ser_out,
  output logic              frame_start
);

  localparam int FRAME_BITS = frame_len(DATA_W, GAP_BITS);
  localparam int PW         = idx_w(FRAME_BITS);
  localparam logic [PW-1:0] LAST_DATA = PW'(DATA_W);

  logic          rst_n_s;
  logic          bit_tick;
  logic          load_now;
  logic [PW-1:0] pos_q;

  generate
    if (GAP_BITS < 2) begin : g_bad_gap
      $error("GAP_BITS must be at least 2");
    end
  endgenerate

  sftx_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  sftx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .bit_tick (bit_tick)
  );

  sftx_frame_seq #(.DATA_W(DATA_W), .GAP_BITS(GAP_BITS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .bit_tick (bit_tick),
    .load_now (load_now),
    .pos_q    (pos_q)
  );

  sftx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .bit_tick    (bit_tick),
    .load_now    (load_now),
    .word_in     (data_in),
    .line_bit    (ser_out),
    .load_strobe (frame_start)
  );

  // R5: once the payload has gone out the line is low for the whole gap
  p_gap_low_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pos_q > LAST_DATA) |-> !ser_out);
  // R6: the frame strobe is a single-cycle pulse
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    frame_start |=> !frame_start);
  // R3: the strobe only appears at the marker slot
  p_strobe_at_marker_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    frame_start |-> (pos_q == '0));

endmodule

// File: tb/test_sframe_tx.sv
module test_sframe_tx;

  localparam int W      = 16;
  localparam int DIV    = 4;
  localparam int GAP    = 3;
  localparam int FBITS  = 1 + W + GAP;
  localparam int FCYC   = FBITS * DIV;
  localparam int NFRAME = 10;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] data_in;
  logic         ser_out;
  logic         frame_start;

  int n_checks;
  int n_fail;

  sframe_tx #(.DATA_W(W), .CLKS_PER_BIT(DIV), .GAP_BITS(GAP)) i_sframe_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_in     (data_in),
    .ser_out     (ser_out),
    .frame_start (frame_start)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // Expected line level at cycle c of a frame holding word w
  function automatic logic exp_line(input int c, input logic [W-1:0] w);
    int bi;
    bi = c / DIV;
    if (bi == 0) return 1'b1;
    if (bi <= W) return w[bi-1];
    return 1'b0;
  endfunction

  function automatic string tag_of(input int c);
    int bi;
    bi = c / DIV;
    if (bi == 0) return "R3";
    if (bi <= W) return "R4,R7";
    return "R5";
  endfunction

  function automatic logic [W-1:0] pick_word(input int f);
    case (f)
      0: return 16'hFFFF;
      1: return 16'h0000;
      2: return 16'h8001;
      3: return 16'hAAAA;
      4: return 16'h0001;
      default: return W'($urandom);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] cur;
    logic [W-1:0] nxt;
    n_checks = 0;
    n_fail   = 0;
    void'($urandom(32'h5EED_0017));
    rst_n   = 1'b0;
    data_in = 16'hA5C3;
    repeat (3) @(negedge clk);
    chk("R1 ser_out in reset", 32'(ser_out), 32'd0);
    chk("R1 frame_start in reset", 32'(frame_start), 32'd0);
    data_in = 16'h3C5A;
    chk("R1 ser_out in reset with new data", 32'(ser_out), 32'd0);
    rst_n = 1'b1;
    cur = data_in;
    for (int n = 1; n <= DIV + 2; n++) begin
      @(negedge clk);
      chk("R2 first load timing", 32'(frame_start), (n == DIV + 2) ? 32'd1 : 32'd0);
      if (n < DIV + 2) chk("R2 line low before first frame", 32'(ser_out), 32'd0);
    end
    for (int f = 0; f < NFRAME; f++) begin
      nxt = pick_word(f);
      for (int c = 0; c < FCYC; c++) begin
        chk(tag_of(c), 32'(ser_out), 32'(exp_line(c, cur)));
        chk("R6 strobe", 32'(frame_start), (c == 0) ? 32'd1 : 32'd0);
        if ((c / DIV) >= 1 && (c / DIV) <= W && (c % 3) == 0)
          data_in = W'($urandom);
        if (c == (W + 1) * DIV)
          data_in = nxt;
        @(negedge clk);
      end
      cur = nxt;
    end
    chk("R6 strobe after last frame", 32'(frame_start), 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 ser_out after mid-run reset", 32'(ser_out), 32'd0);
    chk("R1 frame_start after mid-run reset", 32'(frame_start), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule